// File: doc/BRIEF.md
# Extended-Precision Sign and Round-to-Integer Unit

This unit takes one 80-bit extended-precision operand and applies one of three operations to it: absolute value, sign change, or rounding to an integral value. The operand is made of one sign bit, a 15-bit biased exponent (bias 0x3FFF) and a 64-bit significand whose top bit is the explicit integer bit. A companion input says whether the operand's source register is empty. The unit returns the result and four exception flags: invalid, stack fault, denormal and precision.

Absolute value and sign change work on the sign bit alone. Rounding follows a 2-bit rounding-control input. It passes infinities and NaNs through untouched, and it handles three groups of values separately: values below one in magnitude, values inside the fractional range, and values too large to carry any fraction bits. The result appears in a single registered stage, one clock after the request.

Top module: `xsr_unit`

## Requirements
- R1: Operation code 00 (absolute value) returns the operand with the sign bit cleared and every other bit unchanged, and raises no flag.
- R2: Operation code 01 (sign change) returns the operand with the sign bit inverted and every other bit unchanged, and raises no flag.
- R3: When the empty input is high, every operation raises invalid and stack fault, raises neither denormal nor precision, and returns the indefinite value: sign 1, exponent 0x7FFF, significand 0xC000000000000000.
- R4: Operation codes 10 and 11 round to an integral value using the rounding-control input: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R5: Rounding raises precision only when the input had a nonzero fraction; an input that is already integral, zeros included, comes back bit-for-bit unchanged with no flag.
- R6: Rounding an operand with exponent 0x7FFF (infinity or NaN) returns it unchanged and raises no flag.
- R7: Rounding an operand with exponent 0 and a nonzero significand raises denormal (and precision); sign change and absolute value never raise denormal.
- R8: A nonzero operand below one in magnitude rounds either to a zero that keeps the input's sign (exponent 0, significand 0) or to one with the input's sign (exponent 0x3FFF, significand 0x8000000000000000).
- R9: An operand with exponent 0x3FFF+63 or more passes through rounding unchanged; a rounding increment that carries out of the significand yields exponent+1 with significand 0x8000000000000000.
- R10: The result and flags appear on the clock after a request with out_valid high for exactly that cycle; synchronous reset clears out_valid, result and flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation: 00 abs, 01 sign change, 1x round |
| rc | input | 2 | Rounding control for round operations |
| empty | input | 1 | Operand register is empty |
| operand | input | 80 | Extended value {sign, exponent, significand} |
| out_valid | output | 1 | Result valid |
| result | output | 80 | Extended result |
| flag_invalid | output | 1 | Invalid operation |
| flag_stack_fault | output | 1 | Stack fault |
| flag_denormal | output | 1 | Denormal operand |
| flag_precision | output | 1 | Inexact rounding |

## Verification
The bench pushes exact ties (x.5 with even and odd integer parts, and 0.5 itself) through nearest-even, where a design that rounds ties away from zero returns odd integers and turns 0.5 into one. It runs all-ones significands at the exponents just below the integral limit so that the increment carries out, where a design that drops the carry returns a zero significand with the old exponent. Negative sub-one values under the directed modes expose a design that loses the sign of a zero or rounds the magnitude the wrong way, and integral, infinite and NaN inputs expose a design that raises precision spuriously or quietens a NaN.

// File: rtl/xsr_pkg.sv
package xsr_pkg;

    localparam int EXP_W = 15;
    localparam int SIG_W = 64;
    localparam int VAL_W = 1 + EXP_W + SIG_W;
    localparam int SH_W  = $clog2(SIG_W) + 1;

    localparam logic [EXP_W-1:0] EXP_BIAS     = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] EXP_MAX      = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_HALF     = EXP_BIAS - 1'b1;
    localparam logic [EXP_W-1:0] EXP_INTEGRAL = EXP_BIAS + EXP_W'(SIG_W - 1);

    localparam logic [SIG_W-1:0] SIG_ONE  = {1'b1, {(SIG_W-1){1'b0}}};
    localparam logic [SIG_W-1:0] SIG_QNAN = {2'b11, {(SIG_W-2){1'b0}}};
    localparam logic [SIG_W-1:0] SIG_ONES = {SIG_W{1'b1}};

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } xval_t;

    typedef enum logic [1:0] {
        OP_ABS  = 2'b00,
        OP_CHS  = 2'b01,
        OP_RND  = 2'b10,
        OP_RNDX = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_ZERO = 2'b11
    } rc_e;

    typedef struct packed {
        logic invalid;
        logic stack_fault;
        logic denormal;
        logic precision;
    } xflags_t;

    typedef struct packed {
        logic is_special;
        logic is_zero;
        logic is_denorm;
        logic is_small;
        logic is_integral;
    } xclass_t;

    function automatic xval_t indefinite();
        xval_t v;
        v.sign = 1'b1;
        v.exp  = EXP_MAX;
        v.sig  = SIG_QNAN;
        return v;
    endfunction

    // Magnitude increment decision shared by both rounding paths.
    // half: first discarded bit, sticky: any lower discarded bit,
    // lsb: lowest kept bit.
    function automatic logic round_up(rc_e rc, logic sign, logic half,
                                      logic sticky, logic lsb);
        logic up;
        unique case (rc)
            RC_NEAR: up = half & (sticky | lsb);
            RC_DOWN: up = sign & (half | sticky);
            RC_UP:   up = ~sign & (half | sticky);
            default: up = 1'b0;
        endcase
        return up;
    endfunction

endpackage

// File: rtl/xsr_classify.sv
module xsr_classify
    import xsr_pkg::*;
(
    input  xval_t   x,
    output xclass_t c
);
    logic sig_nz;
    logic exp_max;

    always_comb begin
        sig_nz        = |x.sig;
        exp_max       = (x.exp == EXP_MAX);
        c.is_special  = exp_max;
        c.is_zero     = ~exp_max & ~sig_nz;
        c.is_denorm   = (x.exp == '0) & sig_nz;
        c.is_integral = ~exp_max & sig_nz & (x.exp >= EXP_INTEGRAL);
        c.is_small    = sig_nz & (x.exp < EXP_BIAS);
    end
endmodule

// File: rtl/xsr_sign.sv
module xsr_sign
    import xsr_pkg::*;
(
    input  op_e   op,
    input  xval_t x,
    output xval_t y
);
    always_comb begin
        y = x;
        unique case (op)
            OP_ABS:  y.sign = 1'b0;
            OP_CHS:  y.sign = ~x.sign;
            default: y.sign = x.sign;
        endcase
    end
endmodule

// File: rtl/xsr_round.sv
module xsr_round
    import xsr_pkg::*;
(
    input  rc_e     rc,
    input  xval_t   x,
    input  xclass_t c,
    output xval_t   y,
    output logic    denormal,
    output logic    precision
);
    // Fractional-range path: 0x3FFF <= exp < 0x3FFF+63
    logic [SH_W-1:0]  sh;
    logic [SH_W:0]    fsh;
    logic [SIG_W-1:0] frac_mask;
    logic [SIG_W-1:0] half_mask;
    logic [SIG_W-1:0] rest_mask;
    logic [SIG_W-1:0] lsb_mask;
    logic [SIG_W-1:0] int_part;
    logic [SIG_W:0]   sum;
    logic             m_half, m_sticky, m_lsb, m_up, m_inexact;

    // Below-one path
    logic             s_half, s_sticky, s_up;

    always_comb begin
        sh        = SH_W'(x.exp - EXP_BIAS);
        fsh       = {1'b0, sh} + 1'b1;
        frac_mask = SIG_ONES >> fsh;
        rest_mask = frac_mask >> 1;
        half_mask = frac_mask & ~rest_mask;
        lsb_mask  = half_mask << 1;
        int_part  = x.sig & ~frac_mask;
        m_half    = |(x.sig & half_mask);
        m_sticky  = |(x.sig & rest_mask);
        m_lsb     = |(x.sig & lsb_mask);
        m_inexact = m_half | m_sticky;
        m_up      = round_up(rc, x.sign, m_half, m_sticky, m_lsb);
        sum       = {1'b0, int_part} + (m_up ? {1'b0, lsb_mask} : '0);
    end

    always_comb begin
        s_half   = (x.exp == EXP_HALF) & x.sig[SIG_W-1];
        s_sticky = (x.exp == EXP_HALF) ? |x.sig[SIG_W-2:0] : 1'b1;
        s_up     = round_up(rc, x.sign, s_half, s_sticky, 1'b0);
    end

    always_comb begin
        y         = x;
        precision = 1'b0;
        denormal  = c.is_denorm;
        if (c.is_special || c.is_zero || c.is_integral) begin
            y         = x;
        end else if (c.is_small) begin
            precision = 1'b1;
            y.sign    = x.sign;
            y.exp     = s_up ? EXP_BIAS : '0;
            y.sig     = s_up ? SIG_ONE  : '0;
        end else begin
            precision = m_inexact;
            if (sum[SIG_W]) begin
                y.exp = x.exp + 1'b1;
                y.sig = SIG_ONE;
            end else begin
                y.sig = sum[SIG_W-1:0];
            end
        end
    end
endmodule

// File: rtl/xsr_unit.sv
module xsr_unit
    import xsr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [1:0]   rc,
    input  logic         empty,
    input  logic [79:0]  operand,
    output logic         out_valid,
    output logic [79:0]  result,
    output logic         flag_invalid,
    output logic         flag_stack_fault,
    output logic         flag_denormal,
    output logic         flag_precision
);
    xval_t   x_in;
    xclass_t cls;
    xval_t   y_sign;
    xval_t   y_rnd;
    logic    rnd_den, rnd_prec;
    xval_t   y_next;
    xflags_t f_next;
    xval_t   y_q;
    xflags_t f_q;
    op_e     op_q;

    assign x_in = xval_t'(operand);
    assign op_q = op_e'(op);

    xsr_classify u_cls (
        .x (x_in),
        .c (cls)
    );

    xsr_sign u_sign (
        .op (op_q),
        .x  (x_in),
        .y  (y_sign)
    );

    xsr_round u_rnd (
        .rc        (rc_e'(rc)),
        .x         (x_in),
        .c         (cls),
        .y         (y_rnd),
        .denormal  (rnd_den),
        .precision (rnd_prec)
    );

    always_comb begin
        f_next = '0;
        if (empty) begin
            y_next             = indefinite();
            f_next.invalid     = 1'b1;
            f_next.stack_fault = 1'b1;
        end else if (op_q == OP_ABS || op_q == OP_CHS) begin
            y_next = y_sign;
        end else begin
            y_next           = y_rnd;
            f_next.denormal  = rnd_den;
            f_next.precision = rnd_prec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            y_q       <= '0;
            f_q       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y_q <= y_next;
                f_q <= f_next;
            end
        end
    end

    assign result           = VAL_W'(y_q);
    assign flag_invalid     = f_q.invalid;
    assign flag_stack_fault = f_q.stack_fault;
    assign flag_denormal    = f_q.denormal;
    assign flag_precision   = f_q.precision;

    // R1: abs clears only the sign bit, no flags
    a_r1_abs_sign_only: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !empty && op == 2'b00) |=>
        (result == {1'b0, $past(operand[78:0])} &&
         !flag_invalid && !flag_stack_fault && !flag_denormal && !flag_precision));

    // R2: sign change flips only the sign bit, no flags
    a_r2_chs_sign_only: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !empty && op == 2'b01) |=>
        (result == {~$past(operand[79]), $past(operand[78:0])} &&
         !flag_invalid && !flag_stack_fault && !flag_denormal && !flag_precision));

    // R3: empty operand gives indefinite with invalid and stack fault
    a_r3_empty_indef: assert property (@(posedge clk) disable iff (rst)
        (in_valid && empty) |=>
        (result == {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000} &&
         flag_invalid && flag_stack_fault && !flag_denormal && !flag_precision));

    // R3: stack fault never appears without invalid
    a_r3_sf_with_inv: assert property (@(posedge clk) disable iff (rst)
        flag_stack_fault |-> flag_invalid);

    // R6: infinities and NaNs pass rounding untouched
    a_r6_special_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !empty && op[1] && operand[78:64] == 15'h7FFF) |=>
        (result == $past(operand) && !flag_precision && !flag_denormal && !flag_invalid));

    // R10: one-cycle latency, valid for one cycle per request
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: tb/xsr_unit_tb.sv
`timescale 1ns/100ps
module xsr_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [1:0]  rc = 2'b00;
    logic        empty = 1'b0;
    logic [79:0] operand = '0;
    logic        out_valid;
    logic [79:0] result;
    logic        flag_invalid, flag_stack_fault, flag_denormal, flag_precision;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xsr_unit u_dut (
        .clk              (clk),
        .rst              (rst),
        .in_valid         (in_valid),
        .op               (op),
        .rc               (rc),
        .empty            (empty),
        .operand          (operand),
        .out_valid        (out_valid),
        .result           (result),
        .flag_invalid     (flag_invalid),
        .flag_stack_fault (flag_stack_fault),
        .flag_denormal    (flag_denormal),
        .flag_precision   (flag_precision)
    );

    localparam logic [63:0] ONE_SIG = 64'h8000_0000_0000_0000;

    function automatic logic [79:0] mk(logic s, logic [14:0] e, logic [63:0] m);
        return {s, e, m};
    endfunction

    // Behavioural reference: returns {result, inv, sf, den, prec}
    function automatic logic [83:0] model(logic [1:0] o, logic [1:0] r,
                                          logic em, logic [79:0] x);
        logic s; logic [14:0] e; logic [63:0] m;
        logic [79:0] y; logic up; logic ex;
        int sh, f, cmp;
        logic [63:0] ip, rem, halfv;
        logic [64:0] ipn;
        s = x[79]; e = x[78:64]; m = x[63:0];
        if (em) return {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000, 4'b1100};
        if (o == 2'b00) return {1'b0, x[78:0], 4'b0000};
        if (o == 2'b01) return {~s, x[78:0], 4'b0000};
        if (e == 15'h7FFF || m == 0 || int'(e) >= 16383 + 63) return {x, 4'b0000};
        if (int'(e) < 16383) begin
            if (int'(e) == 16382 && m[63]) cmp = (m == ONE_SIG) ? 0 : 1;
            else cmp = -1;
            case (r)
                2'b00: up = (cmp > 0);
                2'b01: up = s;
                2'b10: up = !s;
                default: up = 1'b0;
            endcase
            y = up ? mk(s, 15'h3FFF, ONE_SIG) : mk(s, 15'h0, 64'h0);
            return {y, 2'b00, (e == 0), 1'b1};
        end
        sh = int'(e) - 16383;
        f = 63 - sh;
        ip = m >> f;
        rem = m - (ip << f);
        halfv = 64'd1 << (f - 1);
        ex = (rem == 0);
        case (r)
            2'b00: up = (rem > halfv) || (rem == halfv && ip[0]);
            2'b01: up = !ex && s;
            2'b10: up = !ex && !s;
            default: up = 1'b0;
        endcase
        ipn = {1'b0, ip} + {64'd0, up};
        if (ipn == (65'd1 << (sh + 1))) y = mk(s, e + 15'd1, ONE_SIG);
        else y = mk(s, e, ipn[63:0] << f);
        return {y, 3'b000, !ex};
    endfunction

    function automatic string req_of(logic [1:0] o, logic em, logic [79:0] x);
        logic [14:0] e; e = x[78:64];
        if (em) return "R3";
        if (o == 2'b00) return "R1";
        if (o == 2'b01) return "R2";
        if (e == 15'h7FFF) return "R6";
        if (x[63:0] == 0) return "R5";
        if (int'(e) >= 16383 + 63) return "R9";
        if (e == 0) return "R7";
        if (int'(e) < 16383) return "R8";
        return "R4/R5";
    endfunction

    task automatic apply(input bit v, input logic [1:0] o, input logic [1:0] r,
                         input bit em, input logic [79:0] x);
        logic [83:0] expv, got;
        string tag;
        @(negedge clk);
        in_valid = v; op = o; rc = r; empty = em; operand = x;
        expv = model(o, r, em, x);
        tag = req_of(o, em, x);
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== v) begin
            errors++;
            $display("FAIL R10 out_valid actual %0b expected %0b", out_valid, v);
        end
        if (v) begin
            checks++;
            got = {result, flag_invalid, flag_stack_fault, flag_denormal, flag_precision};
            if (got !== expv) begin
                errors++;
                $display("FAIL %s op=%0d rc=%0d in=%h actual %h/%b expected %h/%b",
                         tag, o, r, x, got[83:4], got[3:0], expv[83:4], expv[3:0]);
            end
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [79:0] vals [0:17];
        vals[0]  = mk(0, 15'h3FFF, 64'hC000_0000_0000_0000); // 1.5
        vals[1]  = mk(1, 15'h3FFF, 64'hC000_0000_0000_0000); // -1.5
        vals[2]  = mk(0, 15'h4000, 64'hA000_0000_0000_0000); // 2.5 tie even
        vals[3]  = mk(1, 15'h4000, 64'hA000_0000_0000_0000); // -2.5
        vals[4]  = mk(0, 15'h3FFE, ONE_SIG);                 // 0.5 tie to zero
        vals[5]  = mk(1, 15'h3FFE, 64'hC000_0000_0000_0000); // -0.75
        vals[6]  = mk(0, 15'h3FFD, ONE_SIG);                 // 0.25
        vals[7]  = mk(0, 15'h3FFF, 64'hFFFF_FFFF_FFFF_FFFF); // carry to 2
        vals[8]  = mk(1, 15'h403D, 64'hFFFF_FFFF_FFFF_FFFF); // carry at top
        vals[9]  = mk(0, 15'h403E, 64'hFFFF_FFFF_FFFF_FFFF); // R9 already integral
        vals[10] = mk(1, 15'h4100, 64'h8000_0000_0000_0001); // R9 large
        vals[11] = mk(0, 15'h0000, 64'h0000_0000_0000_0001); // R7 denormal
        vals[12] = mk(1, 15'h0000, 64'h7FFF_0000_0000_0000); // R7 negative denormal
        vals[13] = mk(0, 15'h7FFF, ONE_SIG);                 // R6 +inf
        vals[14] = mk(1, 15'h7FFF, 64'h8000_0000_0000_0001); // R6 signalling NaN
        vals[15] = mk(1, 15'h0000, 64'h0);                   // R5 -0
        vals[16] = mk(0, 15'h4002, 64'hA000_0000_0000_0000); // R5 10.0 exact
        vals[17] = mk(0, 15'h3FFF, ONE_SIG);                 // R5 1.0 exact

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || result !== '0 ||
            {flag_invalid, flag_stack_fault, flag_denormal, flag_precision} !== 4'b0) begin
            errors++;
            $display("FAIL R10 reset actual v=%0b res=%h expected 0", out_valid, result);
        end
        @(negedge clk); rst = 1'b0;

        // R1, R2, R4..R9: directed values under every op and rounding mode
        for (int i = 0; i < 18; i++)
            for (int o = 0; o < 4; o++)
                for (int r = 0; r < 4; r++)
                    apply(1'b1, o[1:0], r[1:0], 1'b0, vals[i]);

        // R3: empty operand for every op
        for (int o = 0; o < 4; o++) apply(1'b1, o[1:0], 2'b00, 1'b1, vals[o]);

        // R10: idle cycles keep out_valid low
        apply(1'b0, 2'b10, 2'b00, 1'b0, vals[0]);
        apply(1'b0, 2'b00, 2'b00, 1'b0, vals[1]);

        // Mixed traffic, back-to-back and with gaps
        for (int n = 0; n < 3000; n++) begin
            logic [14:0] e;
            logic [63:0] m;
            int k, sel;
            sel = $urandom_range(0, 19);
            if (sel == 0) e = 15'h0;
            else if (sel == 1) e = 15'h7FFF;
            else e = 15'(16370 + $urandom_range(0, 80));
            m = {$urandom, $urandom};
            k = $urandom_range(0, 63);
            if ($urandom_range(0, 1) == 1) m = m & ~((64'd1 << k) - 64'd1);
            if ($urandom_range(0, 3) != 0) m[63] = (e != 0);
            apply($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)),
                  2'($urandom_range(0, 3)), $urandom_range(0, 15) == 0,
                  mk(1'($urandom_range(0, 1)), e, m));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule